// File: doc/BRIEF.md
# Multi-Queue Receive Descriptor Ring Engine

This block is a bus master that stores one incoming frame into memory through circular rings of receive descriptors. A frame begins with a start pulse that carries its length. Its bytes then arrive one per handshake on a byte stream. The engine looks at four rings in a fixed priority order. It reads descriptors over a 32-bit word master port and picks the first descriptor that is handed to hardware and has a buffer large enough for the frame.

The frame bytes go into the chosen buffer, shifted by an optional two-byte header gap. Unaligned starts and partial words use byte-enable masked writes. After the data, the engine rewrites the length word and then the status word with the hardware flag cleared. It then pulses a per-queue update that moves that queue's walk pointer to the descriptor's next link, and raises the receive cause. If no descriptor qualifies, the engine still accepts every byte of the frame and discards it, and nothing changes. The walk pointers, head pointers and the header-gap setting come from an external register block.

Top module: `rx_ring_engine`

## Requirements
- R1: A descriptor is four 32-bit words, read at offsets 0, 4, 8 and 12 from its address. Word 0 is the status, with bit 31 = 1 meaning owned by hardware. Word 1 holds the buffer size in bits 31:16 and the byte count in bits 15:0. Word 2 is the buffer address and word 3 is the next-descriptor address.
- R2: Queues are searched in order 0, 1, 2, 3, and the first acceptable descriptor wins. A queue whose walk pointer is zero is skipped.
- R3: Inside a queue, the search begins at the walk pointer and follows next links. It leaves the queue once the next link of the descriptor just examined equals that queue's head pointer, so the head descriptor is not examined unless the walk started there.
- R4: A descriptor is taken only when bit 31 of its status is 1 and its buffer size is at least the frame length. A buffer size equal to the frame length is accepted.
- R5: Frame byte i is stored at byte address buffer + gap + i, where gap is 2 when hdrShift is 1 and 0 otherwise. Bytes are little-endian within a word (lane = address bits 1:0, memBe bit n enables bits 8n+7:8n). No byte outside that range changes.
- R6: Word 1 of the taken descriptor is rewritten with the byte count set to frame length + gap and the buffer size unchanged.
- R7: Word 0 of the taken descriptor is rewritten after all frame data, with bit 31 cleared and all other bits kept. A zero-length frame writes only words 1 and 0.
- R8: After the status write, walkWe pulses for one cycle on the taken queue's bit only, with walkNext equal to that descriptor's next link. causeSet pulses in the same cycle.
- R9: If no descriptor qualifies, all frame bytes are still accepted. No memory write occurs and neither walkWe nor causeSet pulses.
- R10: frmReady is 1 only when the engine is idle, and a frame is taken on frmStart while frmReady is 1. inReady is 0 while the engine is idle.
- R11: A memory request holds memReq, memWe, memAddr and memWdata steady until memAck.
- R12: After reset, frmReady is 1 and inReady, memReq and walkWe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hdrShift | input | 1 | Selects the two-byte header gap before frame data |
| walkPtrs | input | 128 | Walk pointer of each queue, queue q in bits 32q+31:32q |
| headPtrs | input | 128 | Head pointer of each queue, same packing |
| walkWe | output | 4 | One-cycle update strobe for the walk pointer of one queue |
| walkNext | output | 32 | New walk pointer value |
| causeSet | output | 1 | One-cycle pulse that sets the receive cause |
| frmStart | input | 1 | Frame start pulse |
| frmLen | input | 16 | Frame length in bytes, sampled with frmStart |
| frmReady | output | 1 | Engine idle and able to take a frame |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inReady | output | 1 | Stream byte accepted when high together with inValid |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word-aligned byte address |
| memBe | output | 4 | Byte enables of a write |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completes this cycle; read data valid |
| memRdata | input | 32 | Read data |

## Verification
The assertions assume that memAck is only raised while memReq is high, and that read data is valid in the cycle of memAck. The bench memory model acknowledges only pending requests, returns the addressed word in that same cycle, and inserts stall cycles in a repeating pattern. The assertions also assume that every ring closes back on its head pointer, because a ring that never returns to the head would keep the search running forever. The bench builds only rings that close, and it changes the pointers and descriptors only while the engine is idle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int SIZE_LSB = 16;

  typedef enum logic [2:0] {
    SEL_D0   = 3'd0,
    SEL_D1   = 3'd1,
    SEL_D2   = 3'd2,
    SEL_D3   = 3'd3,
    SEL_DATA = 3'd4
  } memSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_QSEL, S_READ, S_EVAL, S_FILL,
    S_WDATA, S_WCNT, S_WSTAT, S_DONE, S_DROP
  } state_e;

  typedef struct packed {
    memSel_e sel;
    logic    loadFrame;
    logic    loadWalk;
    logic    capWord;
    logic    advance;
    logic    startPack;
    logic    takeByte;
    logic    flushWord;
  } ctrlStrb_t;

  typedef struct packed {
    logic walkZero;
    logic descOk;
    logic atHead;
    logic lenZero;
    logic lastByte;
    logic wordEnd;
    logic noneLeft;
  } dpStat_t;
endpackage

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int LEN_W = 16,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [QW-1:0]        qSel,
  input  logic                 hdrShift,
  input  logic [LEN_W-1:0]     frmLen,
  input  logic [7:0]           inData,
  input  logic [NQ*WORD_W-1:0] walkPtrs,
  input  logic [NQ*WORD_W-1:0] headPtrs,
  input  logic [WORD_W-1:0]    memRdata,
  output logic [WORD_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    memWdata,
  output logic [3:0]           memBe,
  output logic [WORD_W-1:0]    walkNext,
  output dpStat_t              stat
);
  localparam int SIZE_W = WORD_W - SIZE_LSB;

  logic [WORD_W-1:0] walkArr [NQ];
  logic [WORD_W-1:0] headArr [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_unpack
    assign walkArr[g] = walkPtrs[g*WORD_W +: WORD_W];
    assign headArr[g] = headPtrs[g*WORD_W +: WORD_W];
  end

  logic [WORD_W-1:0] walkSel, headSel;
  assign walkSel = walkArr[qSel];
  assign headSel = headArr[qSel];

  logic [LEN_W-1:0]  lenReg, bytesLeft;
  logic              offReg;
  logic [WORD_W-1:0] curAddr, cmdReg, bufReg, nextReg, wordAddr, wordData;
  logic [SIZE_W-1:0] sizeReg;
  logic [1:0]        lane;
  logic [3:0]        wordBe;

  logic [WORD_W-1:0] startAddr;
  logic [15:0]       countVal;
  assign startAddr = bufReg + (offReg ? 32'd2 : 32'd0);
  assign countVal  = 16'(lenReg) + (offReg ? 16'd2 : 16'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg    <= '0;
      bytesLeft <= '0;
      offReg    <= 1'b0;
      curAddr   <= '0;
      cmdReg    <= '0;
      sizeReg   <= '0;
      bufReg    <= '0;
      nextReg   <= '0;
      wordAddr  <= '0;
      wordData  <= '0;
      wordBe    <= '0;
      lane      <= '0;
    end else begin
      if (strb.loadFrame) begin
        lenReg    <= frmLen;
        bytesLeft <= frmLen;
        offReg    <= hdrShift;
      end
      if (strb.loadWalk) curAddr <= walkSel;
      if (strb.advance)  curAddr <= nextReg;
      if (strb.capWord) begin
        case (strb.sel)
          SEL_D0:  cmdReg  <= memRdata;
          SEL_D1:  sizeReg <= memRdata[WORD_W-1:SIZE_LSB];
          SEL_D2:  bufReg  <= memRdata;
          default: nextReg <= memRdata;
        endcase
      end
      if (strb.startPack) begin
        wordAddr <= {startAddr[WORD_W-1:2], 2'b00};
        lane     <= startAddr[1:0];
        wordBe   <= '0;
      end
      if (strb.takeByte) begin
        wordData[{lane, 3'b000} +: 8] <= inData;
        wordBe[lane] <= 1'b1;
        lane         <= lane + 2'd1;
        bytesLeft    <= bytesLeft - 1'b1;
      end
      if (strb.flushWord) begin
        wordBe   <= '0;
        wordAddr <= wordAddr + 32'd4;
      end
    end
  end

  always_comb begin
    memBe    = 4'hF;
    memWdata = wordData;
    case (strb.sel)
      SEL_D0: begin
        memAddr  = curAddr;
        memWdata = cmdReg & ~(32'd1 << OWN_BIT);
      end
      SEL_D1: begin
        memAddr  = curAddr + 32'd4;
        memWdata = {sizeReg, countVal};
      end
      SEL_D2:  memAddr = curAddr + 32'd8;
      SEL_D3:  memAddr = curAddr + 32'd12;
      default: begin
        memAddr = wordAddr;
        memBe   = wordBe;
      end
    endcase
  end

  assign walkNext      = nextReg;
  assign stat.walkZero = (walkSel == '0);
  assign stat.descOk   = cmdReg[OWN_BIT] && (32'(sizeReg) >= 32'(lenReg));
  assign stat.atHead   = (nextReg == headSel);
  assign stat.lenZero  = (lenReg == '0);
  assign stat.lastByte = (bytesLeft == LEN_W'(1));
  assign stat.wordEnd  = (lane == 2'd3);
  assign stat.noneLeft = (bytesLeft == '0);
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int NQ  = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frmStart,
  input  logic          inValid,
  input  logic          memAck,
  input  dpStat_t       stat,
  output ctrlStrb_t     strb,
  output logic [QW-1:0] qSel,
  output logic          frmReady,
  output logic          inReady,
  output logic          memReq,
  output logic          memWe,
  output logic [NQ-1:0] walkWe,
  output logic          causeSet
);
  localparam logic [QW-1:0] LAST_Q = QW'(NQ - 1);

  state_e        state, nState;
  logic [QW-1:0] qIdx, nQ;
  logic [1:0]    rdIdx, nRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      qIdx  <= '0;
      rdIdx <= '0;
    end else begin
      state <= nState;
      qIdx  <= nQ;
      rdIdx <= nRd;
    end
  end

  assign qSel = qIdx;

  always_comb begin
    strb     = '0;
    strb.sel = SEL_D0;
    nState   = state;
    nQ       = qIdx;
    nRd      = rdIdx;
    frmReady = 1'b0;
    inReady  = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    walkWe   = '0;
    causeSet = 1'b0;
    case (state)
      S_IDLE: begin
        frmReady = 1'b1;
        if (frmStart) begin
          strb.loadFrame = 1'b1;
          nQ     = '0;
          nState = S_QSEL;
        end
      end
      S_QSEL: begin
        if (stat.walkZero) begin
          if (qIdx == LAST_Q) nState = S_DROP;
          else nQ = qIdx + 1'b1;
        end else begin
          strb.loadWalk = 1'b1;
          nRd    = '0;
          nState = S_READ;
        end
      end
      S_READ: begin
        memReq   = 1'b1;
        strb.sel = memSel_e'({1'b0, rdIdx});
        if (memAck) begin
          strb.capWord = 1'b1;
          if (rdIdx == 2'd3) nState = S_EVAL;
          else nRd = rdIdx + 2'd1;
        end
      end
      S_EVAL: begin
        if (stat.descOk) begin
          strb.startPack = 1'b1;
          nState = stat.lenZero ? S_WCNT : S_FILL;
        end else if (stat.atHead) begin
          if (qIdx == LAST_Q) nState = S_DROP;
          else begin
            nQ     = qIdx + 1'b1;
            nState = S_QSEL;
          end
        end else begin
          strb.advance = 1'b1;
          nRd    = '0;
          nState = S_READ;
        end
      end
      S_FILL: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.takeByte = 1'b1;
          if (stat.wordEnd || stat.lastByte) nState = S_WDATA;
        end
      end
      S_WDATA: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.sel = SEL_DATA;
        if (memAck) begin
          strb.flushWord = 1'b1;
          nState = stat.noneLeft ? S_WCNT : S_FILL;
        end
      end
      S_WCNT: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.sel = SEL_D1;
        if (memAck) nState = S_WSTAT;
      end
      S_WSTAT: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.sel = SEL_D0;
        if (memAck) nState = S_DONE;
      end
      S_DONE: begin
        walkWe   = NQ'(1) << qIdx;
        causeSet = 1'b1;
        nState   = S_IDLE;
      end
      S_DROP: begin
        if (stat.noneLeft) nState = S_IDLE;
        else begin
          inReady = 1'b1;
          if (inValid) begin
            strb.takeByte = 1'b1;
            if (stat.lastByte) nState = S_IDLE;
          end
        end
      end
      default: nState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxr_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hdrShift,
  input  logic [NQ*WORD_W-1:0] walkPtrs,
  input  logic [NQ*WORD_W-1:0] headPtrs,
  output logic [NQ-1:0]        walkWe,
  output logic [WORD_W-1:0]    walkNext,
  output logic                 causeSet,
  input  logic                 frmStart,
  input  logic [LEN_W-1:0]     frmLen,
  output logic                 frmReady,
  input  logic                 inValid,
  input  logic [7:0]           inData,
  output logic                 inReady,
  output logic                 memReq,
  output logic                 memWe,
  output logic [WORD_W-1:0]    memAddr,
  output logic [3:0]           memBe,
  output logic [WORD_W-1:0]    memWdata,
  input  logic                 memAck,
  input  logic [WORD_W-1:0]    memRdata
);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

  ctrlStrb_t     strb;
  dpStat_t       stat;
  logic [QW-1:0] qSel;

  rxr_ctrl #(.NQ(NQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .frmStart(frmStart), .inValid(inValid),
    .memAck(memAck), .stat(stat), .strb(strb), .qSel(qSel),
    .frmReady(frmReady), .inReady(inReady), .memReq(memReq),
    .memWe(memWe), .walkWe(walkWe), .causeSet(causeSet)
  );

  rxr_datapath #(.NQ(NQ), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .qSel(qSel), .hdrShift(hdrShift),
    .frmLen(frmLen), .inData(inData), .walkPtrs(walkPtrs),
    .headPtrs(headPtrs), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .walkNext(walkNext), .stat(stat)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          frmReady,
  input logic          inReady,
  input logic [NQ-1:0] walkWe,
  input logic          causeSet,
  input logic          memReq,
  input logic          memWe,
  input logic [31:0]   memAddr,
  input logic [3:0]    memBe,
  input logic [31:0]   memWdata,
  input logic          memAck
);
  // R8
  walk_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(walkWe));

  // R7
  status_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|walkWe) |-> $past(memReq && memWe && memAck && memBe == 4'hF && !memWdata[31]));

  // R8
  cause_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeSet |=> frmReady);

  // R10
  idle_no_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmReady |-> !inReady);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R1
  read_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr[1:0] == 2'b00 && memBe == 4'hF));

  // R5
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memBe != 4'h0 && memAddr[1:0] == 2'b00));
endmodule

bind rx_ring_engine rxr_checker #(.NQ(NQ)) u_rxr_chk (
  .clk(clk), .rstN(rstN), .frmReady(frmReady), .inReady(inReady),
  .walkWe(walkWe), .causeSet(causeSet), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/rx_ring_engine_test.sv
`timescale 1ns/1ps
module rx_ring_engine_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hdrShift = 1'b0;
  logic [31:0]  walkReg [4];
  logic [31:0]  headReg [4];
  logic [127:0] walkPtrs, headPtrs;
  logic [3:0]   walkWe;
  logic [31:0]  walkNext;
  logic         causeSet;
  logic         frmStart = 1'b0;
  logic [15:0]  frmLen = '0;
  logic         frmReady;
  logic         inValid = 1'b0;
  logic [7:0]   inData = '0;
  logic         inReady;
  logic         memReq, memWe, memAck;
  logic [31:0]  memAddr, memWdata, memRdata;
  logic [3:0]   memBe;

  logic [31:0]  mem [256];
  logic         pokeEn = 1'b0;
  logic [7:0]   pokeIdx = '0;
  logic [31:0]  pokeVal = '0;
  logic [7:0]   ackCnt = '0;
  int           memWrites = 0, pulses = 0, causes = 0, holdViol = 0;
  int           lastQ = -1;
  logic [31:0]  lastNext = '0;
  logic         pend = 1'b0;
  logic [31:0]  pendAddr = '0;
  int           checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  assign walkPtrs = {walkReg[3], walkReg[2], walkReg[1], walkReg[0]};
  assign headPtrs = {headReg[3], headReg[2], headReg[1], headReg[0]};
  assign memAck   = memReq && ((ackCnt % 5) != 8'd2);
  assign memRdata = mem[memAddr[9:2]];

  rx_ring_engine uut (
    .clk(clk), .rstN(rstN), .hdrShift(hdrShift), .walkPtrs(walkPtrs),
    .headPtrs(headPtrs), .walkWe(walkWe), .walkNext(walkNext),
    .causeSet(causeSet), .frmStart(frmStart), .frmLen(frmLen),
    .frmReady(frmReady), .inValid(inValid), .inData(inData),
    .inReady(inReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always @(negedge clk) ackCnt <= ackCnt + 8'd1;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (pokeEn) mem[pokeIdx] <= pokeVal;
    else if (memReq && memWe && memAck) begin
      memWrites <= memWrites + 1;
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[9:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end
    if (rstN) begin
      if (pend && (!memReq || memAddr != pendAddr)) holdViol <= holdViol + 1;
      pend     <= memReq && !memAck;
      pendAddr <= memAddr;
      if (|walkWe) begin
        pulses   <= pulses + 1;
        lastNext <= walkNext;
        for (int q = 0; q < 4; q++) if (walkWe[q]) lastQ <= q;
      end
      if (causeSet) causes <= causes + 1;
    end
    if (cycles > 150000) begin
      $display("FAIL watchdog R10 act=%0d exp=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'(seed * 11 + i * 37 + 1);
  endfunction

  task automatic pokeW(input logic [31:0] addr, input logic [31:0] val);
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = addr[9:2]; pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] a, input bit own, input logic [15:0] size,
                         input logic [31:0] buff, input logic [31:0] nxt);
    pokeW(a,      {own, 31'h0000_005A});
    pokeW(a + 4,  {size, 16'hFFFF});
    pokeW(a + 8,  buff);
    pokeW(a + 12, nxt);
  endtask

  task automatic setQ(input int q, input logic [31:0] w, input logic [31:0] h);
    walkReg[q] = w;
    headReg[q] = h;
  endtask

  task automatic sendFrame(input int len, input int seed);
    int guard;
    @(negedge clk);
    frmLen = 16'(len); frmStart = 1'b1;
    @(negedge clk);
    frmStart = 1'b0;
    chk(frmReady == 1'b0, "R10 busy after start", 32'(frmReady), 32'd0);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inData = bval(seed, i);
      guard = 0;
      while (!inReady && guard < 4000) begin @(negedge clk); guard++; end
      @(negedge clk);
    end
    inValid = 1'b0;
    guard = 0;
    while (!frmReady && guard < 4000) begin @(negedge clk); guard++; end
    chk(guard < 4000, "R9 frame completes", 32'(guard), 32'd0);
  endtask

  initial begin
    for (int q = 0; q < 4; q++) begin walkReg[q] = '0; headReg[q] = '0; end
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(frmReady == 1'b1, "R12 frmReady", 32'(frmReady), 32'd1);
    chk(inReady == 1'b0 && memReq == 1'b0 && walkWe == 4'd0, "R12 idle outputs",
        {inReady, memReq, walkWe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep: gap x length x buffer alignment, single-descriptor ring on queue 0
    for (int off = 0; off < 2; off++)
      for (int len = 1; len <= 9; len++)
        for (int bl = 0; bl < 4; bl++) begin
          logic [31:0] buff;
          int p0, c0, seed;
          seed = off * 100 + len * 4 + bl;
          buff = 32'h200 + 32'(bl);
          for (int w = 0; w < 9; w++) pokeW(32'h1FC + 32'(4 * w), 32'hEEEE_EEEE);
          putDesc(32'h40, 1'b1, 16'd64, buff, 32'h40);
          setQ(0, 32'h40, 32'h40);
          hdrShift = off[0];
          p0 = pulses; c0 = causes;
          sendFrame(len, seed);
          chk(pulses == p0 + 1 && lastQ == 0, "R8 walk pulse q0", 32'(lastQ), 32'd0);
          chk(lastNext == 32'h40, "R1 next link", lastNext, 32'h40);
          chk(causes == c0 + 1, "R8 cause", 32'(causes - c0), 32'd1);
          chk(mem[32'h44 >> 2] == {16'd64, 16'(len + 2 * off)}, "R6 count word",
              mem[32'h44 >> 2], {16'd64, 16'(len + 2 * off)});
          chk(mem[32'h40 >> 2] == 32'h0000_005A, "R7 status", mem[32'h40 >> 2], 32'h5A);
          for (int k = -1; k <= 2 * off + len; k++) begin
            logic [7:0] e;
            if (k < 2 * off || k >= 2 * off + len) e = 8'hEE;
            else e = bval(seed, k - 2 * off);
            chk(byteAt(buff + 32'(k)) == e, "R5 byte", 32'(byteAt(buff + 32'(k))), 32'(e));
          end
        end

    // Zero-length frame with gap
    hdrShift = 1'b1;
    putDesc(32'h40, 1'b1, 16'd8, 32'h200, 32'h40);
    setQ(0, 32'h40, 32'h40);
    begin
      int w0;
      w0 = memWrites;
      sendFrame(0, 1);
      chk(memWrites == w0 + 2, "R7 zero len writes", 32'(memWrites - w0), 32'd2);
      chk(mem[32'h44 >> 2] == {16'd8, 16'd2}, "R6 zero len count", mem[32'h44 >> 2], {16'd8, 16'd2});
    end
    hdrShift = 1'b0;

    // Priority: q0 zero, q1 not owned, q2 and q3 owned -> q2
    putDesc(32'h60, 1'b0, 16'd64, 32'h300, 32'h60);
    putDesc(32'h80, 1'b1, 16'd64, 32'h300, 32'h80);
    putDesc(32'hA0, 1'b1, 16'd64, 32'h320, 32'hA0);
    setQ(0, 32'h0, 32'h0); setQ(1, 32'h60, 32'h60);
    setQ(2, 32'h80, 32'h80); setQ(3, 32'hA0, 32'hA0);
    sendFrame(5, 7);
    chk(lastQ == 2, "R2 queue priority", 32'(lastQ), 32'd2);
    chk(mem[32'hA0 >> 2][31] == 1'b1, "R2 lower queue untouched", mem[32'hA0 >> 2], 32'h8000_005A);
    chk(mem[32'h60 >> 2][31] == 1'b0 && mem[32'h64 >> 2][15:0] == 16'hFFFF,
        "R4 unowned untouched", mem[32'h64 >> 2], {16'd64, 16'hFFFF});

    // Size skip: A too small, B not owned, C exact size
    putDesc(32'h40, 1'b1, 16'd5, 32'h300, 32'h50);
    putDesc(32'h50, 1'b0, 16'd64, 32'h300, 32'h60);
    putDesc(32'h60, 1'b1, 16'd6, 32'h320, 32'h40);
    setQ(0, 32'h40, 32'h40); setQ(1, 0, 0); setQ(2, 0, 0); setQ(3, 0, 0);
    sendFrame(6, 9);
    chk(lastQ == 0 && lastNext == 32'h40, "R4 exact size taken", lastNext, 32'h40);
    chk(mem[32'h64 >> 2] == {16'd6, 16'd6}, "R4 count on C", mem[32'h64 >> 2], {16'd6, 16'd6});
    chk(mem[32'h40 >> 2] == 32'h8000_005A, "R4 small buffer skipped", mem[32'h40 >> 2], 32'h8000_005A);

    // Ring end: walk at B, head A, only A owned -> queue 1 used
    putDesc(32'h40, 1'b1, 16'd64, 32'h300, 32'h50);
    putDesc(32'h50, 1'b0, 16'd64, 32'h300, 32'h60);
    putDesc(32'h60, 1'b0, 16'd64, 32'h300, 32'h40);
    putDesc(32'h80, 1'b1, 16'd64, 32'h340, 32'h80);
    setQ(0, 32'h50, 32'h40); setQ(1, 32'h80, 32'h80);
    sendFrame(4, 3);
    chk(lastQ == 1, "R3 stop at head link", 32'(lastQ), 32'd1);
    chk(mem[32'h40 >> 2] == 32'h8000_005A, "R3 head not examined", mem[32'h40 >> 2], 32'h8000_005A);

    // Drop: nothing owned anywhere
    putDesc(32'h80, 1'b0, 16'd64, 32'h340, 32'h80);
    begin
      int w0, p0, c0;
      w0 = memWrites; p0 = pulses; c0 = causes;
      sendFrame(7, 5);
      chk(memWrites == w0, "R9 no writes", 32'(memWrites - w0), 32'd0);
      chk(pulses == p0 && causes == c0, "R9 no pulses", 32'(pulses - p0 + causes - c0), 32'd0);
      setQ(0, 0, 0); setQ(1, 0, 0);
      sendFrame(3, 6);
      chk(memWrites == w0 && pulses == p0, "R9 all walks zero", 32'(memWrites - w0), 32'd0);
    end

    chk(holdViol == 0, "R11 request held", 32'(holdViol), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule